// File: doc/BRIEF.md
# Single-Wire Bus Master

This block is a byte-register peripheral that lets a host processor run the low-level time slots of a single-wire, open-drain bus. The host stores a clock divider so that the timing engine steps once per microsecond. It then starts one operation by setting a single command bit in the control register. Three operations exist: a bus reset with presence detection, a write-0 slot, and a write-1 slot that also reads the bus.

While an operation runs, its command bit reads back 1. The bit clears by itself when the slot is over. The host polls that bit. It then reads the presence flag, or the level sampled in the last bit slot, from the same control register. The pin output only ever pulls the line low or releases it. The line level comes back in through a two-stage synchronizer.

Higher-level sequencing is left to software: bytes, device search and checksums.

Top module: `onewire_master`

## Requirements
- R1: Control register at byte offset 0x00 and divider register (8-bit, read/write) at offset 0x02; any other offset reads 0x00; after reset both registers read 0x00.
- R2: While an operation runs, one microsecond tick occurs every divider+1 clocks, with the count restarting at command acceptance; a divider of 0 gives one tick per clock, so a 65 µs slot then lasts exactly 65 clocks.
- R3: A control write while idle starts a reset if bit 7 is 1, otherwise a write-0 slot if bit 5 is 1, otherwise a read slot if bit 4 is 1. The bit of the running operation reads 1 from the next cycle on and clears by itself at the end; at most one of bits 7, 5 and 4 reads 1.
- R4: Reset: the line is driven low for the first 480 µs and presence is sampled at 550 µs. Control bit 6 becomes 1 if the line was low at that point, otherwise 0. The operation ends at 960 µs.
- R5: Write-0 slot: the line is driven low for the first 60 µs and the slot ends at 65 µs.
- R6: Read slot: the line is driven low for the first 6 µs and sampled at 15 µs into control bit 3, and the slot ends at 65 µs. A write-0 slot also loads bit 3 at 15 µs.
- R7: The drive-low output is 0 whenever no operation runs.
- R8: The bus input passes two flops, which reset to 1, before it is sampled. A level change within one clock of the sample tick is therefore not seen.
- R9: Control writes that arrive while an operation runs are ignored and are not queued.
- R10: Control bits 6 and 3 are read-only. A control write with only those bits set starts nothing and changes nothing. Each bit keeps its value until its next sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| bus_i | input | 1 | Sensed bus line level |
| bus_drive_low_o | output | 1 | 1 pulls the bus low, 0 releases it |

## Verification
The bench targets three timing edges.

The first is the exact slot length with divider values 3 and 0. A tick counter that does not restart at acceptance would stretch or shorten each slot by up to one microsecond. An off-by-one divider compare would scale every slot.

The second is the bus line released one clock before a read sample. A design without the two-flop synchronizer, or with only one flop, latches a 1 where 0 is expected.

The third covers command collisions. A write that sets several command bits must start a reset. Commands written during a busy reset must not start or queue another slot. A write of only the read-only bits must leave both status bits untouched.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RST  = 2'd1,
    OP_W0   = 2'd2,
    OP_RD   = 2'd3
  } op_e;

  localparam int CTRL_OFS = 0;
  localparam int DIV_OFS  = 2;

  localparam int B_RST  = 7;
  localparam int B_PRES = 6;
  localparam int B_W0   = 5;
  localparam int B_RD   = 4;
  localparam int B_BIT  = 3;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = en_i && !clr_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R2: zero divider must tick on every running clock
  p_div0_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && div_i == '0) |-> tick_o);
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[0] <= 1'b1;
          else         sr_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[i] <= 1'b1;
          else         sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int RST_LOW_US  = 480,
  parameter int RST_SMP_US  = 550,
  parameter int RST_END_US  = 960,
  parameter int W0_LOW_US   = 60,
  parameter int W0_END_US   = 65,
  parameter int RD_LOW_US   = 6,
  parameter int RD_SMP_US   = 15,
  parameter int RD_END_US   = 65
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_req_i,
  input  logic tick_i,
  input  logic line_i,
  output logic accept_o,
  output op_e  op_o,
  output logic pres_o,
  output logic bit_o,
  output logic drive_low_o
);
  localparam int MAX_A  = (RST_END_US > W0_END_US) ? RST_END_US : W0_END_US;
  localparam int MAX_US = (MAX_A > RD_END_US) ? MAX_A : RD_END_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  op_e             op_q;
  logic [US_W-1:0] us_q;
  logic [US_W-1:0] us_nx;
  logic [US_W-1:0] low_lim, smp_lim, end_lim;
  logic            pres_q, bit_q;

  always_comb begin
    unique case (op_q)
      OP_RST: begin
        low_lim = US_W'(RST_LOW_US); smp_lim = US_W'(RST_SMP_US); end_lim = US_W'(RST_END_US);
      end
      OP_W0: begin
        low_lim = US_W'(W0_LOW_US);  smp_lim = US_W'(RD_SMP_US);  end_lim = US_W'(W0_END_US);
      end
      OP_RD: begin
        low_lim = US_W'(RD_LOW_US);  smp_lim = US_W'(RD_SMP_US);  end_lim = US_W'(RD_END_US);
      end
      default: begin
        low_lim = '0; smp_lim = '0; end_lim = '0;
      end
    endcase
  end

  assign accept_o    = start_i && (op_q == OP_IDLE);
  assign us_nx       = us_q + 1'b1;
  assign drive_low_o = (op_q != OP_IDLE) && (us_q < low_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_IDLE;
      us_q <= '0;
    end else if (accept_o) begin
      op_q <= op_req_i;
      us_q <= '0;
    end else if (op_q != OP_IDLE && tick_i) begin
      us_q <= us_nx;
      if (us_nx == end_lim) op_q <= OP_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres_q <= 1'b0;
      bit_q  <= 1'b0;
    end else if (op_q != OP_IDLE && tick_i && us_nx == smp_lim) begin
      if (op_q == OP_RST) pres_q <= !line_i;
      else                bit_q  <= line_i;
    end
  end

  assign op_o   = op_q;
  assign pres_o = pres_q;
  assign bit_o  = bit_q;

  // R9: busy engine keeps its operation when a new command arrives
  p_ignore_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_IDLE && start_i) |=> (op_q == $past(op_q) || op_q == OP_IDLE));
  // R4: microsecond count never reaches the end bound while running
  p_us_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_IDLE) |-> (us_q < end_lim));
  // R10: presence only moves during a reset
  p_pres_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_RST) |=> $stable(pres_q));
  // R10: sampled bit only moves during a bit slot
  p_bit_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_IDLE || op_q == OP_RST) |=> $stable(bit_q));
  // R7: line released the cycle after an operation ends
  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_IDLE && tick_i && us_nx == end_lim && !accept_o) |=> !drive_low_o);
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DIV_W      = 8,
  parameter int SYNC_STG   = 2,
  parameter int RST_LOW_US = 480,
  parameter int RST_SMP_US = 550,
  parameter int RST_END_US = 960,
  parameter int W0_LOW_US  = 60,
  parameter int W0_END_US  = 65,
  parameter int RD_LOW_US  = 6,
  parameter int RD_SMP_US  = 15,
  parameter int RD_END_US  = 65
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              we_i,
  output logic [7:0]        rdata_o,
  input  logic              bus_i,
  output logic              bus_drive_low_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DIV_OFS);

  logic [DIV_W-1:0] div_q;
  logic             start, accept, tick, line_s, pres, smp_bit, busy;
  op_e              op, op_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      div_q <= '0;
    else if (we_i && addr_i == A_DIV) div_q <= wdata_i[DIV_W-1:0];
  end

  assign start = we_i && (addr_i == A_CTRL) &&
                 (wdata_i[B_RST] || wdata_i[B_W0] || wdata_i[B_RD]);

  always_comb begin
    if (wdata_i[B_RST])     op_req = OP_RST;
    else if (wdata_i[B_W0]) op_req = OP_W0;
    else                    op_req = OP_RD;
  end

  assign busy = (op != OP_IDLE);

  owm_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_i), .q_o(line_s)
  );

  owm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .en_i(busy),
    .div_i(div_q), .tick_o(tick)
  );

  owm_engine #(
    .RST_LOW_US(RST_LOW_US), .RST_SMP_US(RST_SMP_US), .RST_END_US(RST_END_US),
    .W0_LOW_US(W0_LOW_US), .W0_END_US(W0_END_US),
    .RD_LOW_US(RD_LOW_US), .RD_SMP_US(RD_SMP_US), .RD_END_US(RD_END_US)
  ) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .op_req_i(op_req),
    .tick_i(tick), .line_i(line_s), .accept_o(accept), .op_o(op),
    .pres_o(pres), .bit_o(smp_bit), .drive_low_o(bus_drive_low_o)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_CTRL) begin
      rdata_o[B_RST]  = (op == OP_RST);
      rdata_o[B_PRES] = pres;
      rdata_o[B_W0]   = (op == OP_W0);
      rdata_o[B_RD]   = (op == OP_RD);
      rdata_o[B_BIT]  = smp_bit;
    end else if (addr_i == A_DIV) begin
      rdata_o[DIV_W-1:0] = div_q;
    end
  end

  // R3: an accepted command shows its busy bit on the next cycle
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy);
  // R7: no drive without a running operation
  p_drive_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !bus_drive_low_o);
endmodule

// File: tb/onewire_master_test.sv
`timescale 1ns/1ps
module onewire_master_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       we;
  logic [7:0] rdata;
  logic       drv;
  logic       dev_pull;
  logic       bus;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  assign bus = !drv && !dev_pull;

  onewire_master uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .bus_i(bus), .bus_drive_low_o(drv)
  );

  // behavioural reference: 0 idle, 1 reset, 2 write-0, 3 read
  int m_op, m_us, m_pre, m_div, m_pres, m_bit, s1, s2, line_m;

  function automatic int low_of(int op);
    return (op == 1) ? 480 : (op == 2) ? 60 : (op == 3) ? 6 : 0;
  endfunction
  function automatic int smp_of(int op);
    return (op == 1) ? 550 : 15;
  endfunction
  function automatic int end_of(int op);
    return (op == 1) ? 960 : 65;
  endfunction
  function automatic int m_drive();
    return (m_op != 0 && m_us < low_of(m_op)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_op = 0; m_us = 0; m_pre = 0; m_div = 0; m_pres = 0; m_bit = 0; s1 = 1; s2 = 1;
    end else begin
      line_m = (m_drive() == 1 || dev_pull) ? 0 : 1;
      if (m_op != 0) begin
        if (m_pre == m_div) begin
          m_pre = 0;
          m_us  = m_us + 1;
          if (m_us == smp_of(m_op)) begin
            if (m_op == 1) m_pres = (s2 == 0) ? 1 : 0;
            else           m_bit  = s2;
          end
          if (m_us == end_of(m_op)) m_op = 0;
        end else m_pre = m_pre + 1;
      end else if (we && addr == 4'd0 && (wdata[7] || wdata[5] || wdata[4])) begin
        m_op  = wdata[7] ? 1 : (wdata[5] ? 2 : 3);
        m_us  = 0;
        m_pre = 0;
      end
      if (we && addr == 4'd2) m_div = wdata;
      s2 = s1;
      s1 = line_m;
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !ended) begin
      chk(m_op == 1 ? "R4" : m_op == 2 ? "R5" : m_op == 3 ? "R6" : "R7",
          drv, m_drive(), "drive");
      if (addr == 4'd0) begin
        chk("R3", {rdata[7], rdata[5], rdata[4]},
            {m_op == 1, m_op == 2, m_op == 3}, "busy bits");
        chk("R4", rdata[6], m_pres, "presence");
        chk("R6", rdata[3], m_bit, "sampled bit");
      end else if (addr == 4'd2) begin
        chk("R1", rdata, m_div, "divider");
      end else begin
        chk("R1", rdata, 0, "unmapped");
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 4'd0; wdata = 8'h00;
  endtask

  task automatic wait_idle();
    while (m_op != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic busy_len(int bitpos, output int n);
    n = 0;
    while (rdata[bitpos]) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; we = 1'b0; addr = 4'd0; wdata = 8'h00; dev_pull = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", rdata, 0, "reset control");
    chk("R7", drv, 0, "reset drive");
    addr = 4'd2; #1;
    chk("R1", rdata, 0, "reset divider");
    addr = 4'd4; #1;
    chk("R1", rdata, 0, "offset 4");
    addr = 4'd0;
    rst_n = 1'b1;

    wr(4'd2, 8'd3);
    addr = 4'd2; #1;
    chk("R1", rdata, 3, "divider readback");
    addr = 4'd0; #1;

    // reset with a device present
    dev_pull = 1'b1;
    wr(4'd0, 8'h80);
    chk("R3", rdata[7], 1, "reset busy set");
    busy_len(7, n);
    chk("R4", n, 960 * 4, "reset length");
    chk("R4", rdata[6], 1, "presence seen");
    dev_pull = 1'b0;

    wr(4'd0, 8'h80);
    wait_idle();
    chk("R4", rdata[6], 0, "no presence");

    wr(4'd0, 8'h20);
    chk("R3", {rdata[7], rdata[5], rdata[4]}, 3'b010, "write-0 busy only");
    busy_len(5, n);
    chk("R5", n, 65 * 4, "write-0 length");
    chk("R6", rdata[3], 0, "write-0 sampled low");

    wr(4'd0, 8'h10);
    busy_len(4, n);
    chk("R6", n, 65 * 4, "read length");
    chk("R6", rdata[3], 1, "read released bus");

    // R10: read-only bits only
    wr(4'd0, 8'h48);
    @(negedge clk);
    chk("R10", rdata, 8'h08, "read-only write");

    dev_pull = 1'b1;
    wr(4'd0, 8'h10);
    wait_idle();
    chk("R6", rdata[3], 0, "read device low");
    dev_pull = 1'b0;

    // R3 priority, R9 ignored during busy
    wr(4'd0, 8'hB0);
    chk("R3", rdata[7:4], 4'b1000, "priority picks reset");
    wr(4'd0, 8'h20);
    wr(4'd0, 8'h10);
    chk("R9", {rdata[7], rdata[5], rdata[4]}, 3'b100, "busy write ignored");
    wait_idle();
    @(negedge clk);
    chk("R9", {rdata[7], rdata[5], rdata[4]}, 3'b000, "nothing queued");
    chk("R7", drv, 0, "idle drive");

    // R2 zero divider
    wr(4'd2, 8'd0);
    wr(4'd0, 8'h10);
    busy_len(4, n);
    chk("R2", n, 65, "div0 read length");

    // R8 release one clock before the sample tick
    wr(4'd2, 8'd3);
    dev_pull = 1'b1;
    wr(4'd0, 8'h10);
    repeat (58) @(negedge clk);
    dev_pull = 1'b0;
    wait_idle();
    chk("R8", rdata[3], 0, "synchronizer delay");

    repeat (4) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule